// File: doc/BRIEF.md
# Audio Sample FIFO with Level Watermarks

This block is a 128-byte elastic buffer between a register or DMA port and a serial audio shifter. One parameter sets its orientation. In transmit orientation the bus fills the buffer and the shifter drains it. In receive orientation the shifter fills it and the bus drains it. Every transfer moves one entry, and the entry is 1, 2 or 4 bytes wide as programmed. Occupancy is always counted in bytes.

A two-bit command port clears, starts and stops the buffer. The normal bring-up order is: clear, then write zero, then start; the serial side is enabled only after that. A control word holds the entry width and a byte threshold. A second word holds three 5-bit watermarks, counted in 32-bit words, which drive a request, a mid-level and an urgent output.

The transmit orientation tests each condition as "level below a mark". The receive orientation tests it as "level above a mark", so the default watermark orders of the two orientations are mirrors of each other. Sticky flags record a dropped push (overflow) and a failed pop (underflow).

Top module: `afifo_wm`

## Requirements
- R1: After reset the buffer is stopped and empty. Status reads 0x100, and both sticky flags are clear. The entry width is 32-bit and the threshold is 64 bytes. The watermarks (request/mid/urgent) are 27/14/4 words in transmit orientation and 4/14/27 in receive orientation.
- R2: A command with bit 0 set empties the buffer in one cycle. It resets both pointers and the level, clears both sticky flags and leaves the buffer stopped. A push or pop in that same cycle has no effect.
- R3: A command with bit 0 clear loads bit 1 into the running state, so 2 starts the buffer and 0 stops it with its contents kept. While the buffer is stopped, pushes and pops change neither the level, nor pop_data, nor the flags.
- R4: Control-word bits 1:0 select the entry width: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. A push stores push_data lanes from bit 0 upward, and a pop returns the same lanes with the unused upper bits at zero.
- R5: Bytes leave in the order they entered, and the storage wraps around its 128-byte capacity.
- R6: Status bits 6:0 give the level in bytes modulo 128. Bit 7 is set at exactly 128 bytes and bit 8 at exactly 0 bytes, so the two are never set together.
- R7: A push that needs more bytes than are free is dropped whole and sets the sticky overflow flag.
- R8: A pop when fewer bytes are held than one entry returns zero on pop_data, leaves the level unchanged and sets the sticky underflow flag.
- R9: When a push and a pop happen in the same cycle, each is accepted or refused on the level before that cycle. The level then changes by the sum of the accepted parts.
- R10: Control-word bits 8:2 give a byte threshold. thr_evt is high when level <= threshold in transmit orientation, and when level >= threshold in receive orientation.
- R11: The watermark word holds the request mark at bits 4:0, the mid mark at bits 14:10 and the urgent mark at bits 24:20. Each output compares level/4 (rounded down) with its mark: it is high when level/4 < mark in transmit orientation, and when level/4 > mark in receive orientation.
- R12: bound_evt is high while the buffer is empty in transmit orientation, and while it is full in receive orientation.
- R13: Control and watermark words can be written at any time and take effect on the next cycle. A clear command leaves both of them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_wr | input | 1 | Command strobe |
| op_cmd | input | 2 | Command: bit 0 clear, bit 1 start |
| cfg_wr | input | 1 | Control-word write strobe |
| cfg_wdata | input | 32 | Control word: width [1:0], threshold [8:2] |
| wm_wr | input | 1 | Watermark-word write strobe |
| wm_wdata | input | 32 | Watermarks at [4:0], [14:10], [24:20] |
| push_en | input | 1 | Push one entry |
| push_data | input | 32 | Entry to push, lanes from bit 0 |
| pop_en | input | 1 | Pop one entry |
| pop_data | output | 32 | Last popped entry, or zero after an underflow |
| running | output | 1 | Buffer started |
| status | output | 9 | {empty, full, level[6:0]} |
| lvl_req | output | 1 | Request watermark condition |
| lvl_mid | output | 1 | Mid watermark condition |
| lvl_urg | output | 1 | Urgent watermark condition |
| thr_evt | output | 1 | Threshold condition |
| bound_evt | output | 1 | Empty (transmit) or full (receive) event |
| ovf_flag | output | 1 | Sticky overflow |
| unf_flag | output | 1 | Sticky underflow |

## Verification
The bound checker watches every cycle for the clear command's one-cycle effect and for a stopped buffer holding its status and pop_data. It also checks that a push at full always raises overflow, that a pop at empty raises underflow with a zero result, and that full and empty are never reported together. Byte order across the wrap, the zero fill of narrow entries, and the acceptance rule for a push and a pop in the same cycle can only be shown by the bench's scenarios. The same holds for both orientations' threshold and watermark comparisons and for the configuration surviving a clear. The bench drives two instances, one per orientation, with the same stimulus.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

  typedef enum logic [1:0] {
    EW_BYTE  = 2'd0,
    EW_HALF  = 2'd1,
    EW_WORD  = 2'd2,
    EW_WORD3 = 2'd3
  } ent_width_e;

  localparam int CTL_WIDTH_LSB = 0;
  localparam int CTL_THR_LSB   = 2;
  localparam int WM_REQ_LSB    = 0;
  localparam int WM_MID_LSB    = 10;
  localparam int WM_URG_LSB    = 20;
  localparam int LANES         = 4;

  function automatic logic [2:0] ent_bytes(input ent_width_e w);
    case (w)
      EW_BYTE: ent_bytes = 3'd1;
      EW_HALF: ent_bytes = 3'd2;
      default: ent_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/afifo_cfg.sv
module afifo_cfg
  import afifo_pkg::*;
#(
  parameter bit IS_TX   = 1'b1,
  parameter int DEPTH   = 128,
  parameter int THR_W   = 7,
  parameter int WM_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_wr,
  input  logic [1:0]       op_cmd,
  input  logic             cfg_wr,
  input  logic [31:0]      cfg_wdata,
  input  logic             wm_wr,
  input  logic [31:0]      wm_wdata,
  output logic             running,
  output logic             clr,
  output ent_width_e       width,
  output logic [THR_W-1:0] thr,
  output logic [WM_W-1:0]  wm_req,
  output logic [WM_W-1:0]  wm_mid,
  output logic [WM_W-1:0]  wm_urg
);

  localparam int DEF_THR = DEPTH / 2;
  localparam int DEF_REQ = IS_TX ? 27 : 4;
  localparam int DEF_MID = 14;
  localparam int DEF_URG = IS_TX ? 4 : 27;

  logic             run_q, run_d;
  ent_width_e       width_q, width_d;
  logic [THR_W-1:0] thr_q, thr_d;
  logic [WM_W-1:0]  req_q, req_d, mid_q, mid_d, urg_q, urg_d;

  assign clr = op_wr & op_cmd[0];

  always_comb begin
    run_d = run_q;
    if (op_wr) begin
      if (op_cmd[0]) run_d = 1'b0;
      else           run_d = op_cmd[1];
    end
  end

  always_comb begin
    width_d = width_q;
    thr_d   = thr_q;
    if (cfg_wr) begin
      width_d = ent_width_e'(cfg_wdata[CTL_WIDTH_LSB +: 2]);
      thr_d   = cfg_wdata[CTL_THR_LSB +: THR_W];
    end
  end

  always_comb begin
    req_d = req_q;
    mid_d = mid_q;
    urg_d = urg_q;
    if (wm_wr) begin
      req_d = wm_wdata[WM_REQ_LSB +: WM_W];
      mid_d = wm_wdata[WM_MID_LSB +: WM_W];
      urg_d = wm_wdata[WM_URG_LSB +: WM_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      width_q <= EW_WORD;
      thr_q   <= THR_W'(DEF_THR);
      req_q   <= WM_W'(DEF_REQ);
      mid_q   <= WM_W'(DEF_MID);
      urg_q   <= WM_W'(DEF_URG);
    end else begin
      run_q <= run_d;
      if (cfg_wr) begin
        width_q <= width_d;
        thr_q   <= thr_d;
      end
      if (wm_wr) begin
        req_q <= req_d;
        mid_q <= mid_d;
        urg_q <= urg_d;
      end
    end
  end

  assign running = run_q;
  assign width   = width_q;
  assign thr     = thr_q;
  assign wm_req  = req_q;
  assign wm_mid  = mid_q;
  assign wm_urg  = urg_q;

endmodule

// File: rtl/afifo_store.sv
module afifo_store
  import afifo_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic          push_en,
  input  logic [31:0]   push_data,
  input  logic          pop_en,
  input  logic [2:0]    nbytes,
  output logic [CW-1:0] count,
  output logic [31:0]   pop_data,
  output logic          ovf,
  output logic          unf
);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_ptr, wr_ptr_d, rd_ptr, rd_ptr_d;
  logic [CW-1:0] count_d;
  logic [31:0]   pop_d;
  logic          ovf_d, unf_d;
  logic          push_try, pop_try, fits, avail, push_ok, pop_ok;
  logic [CW-1:0] add_n, sub_n;

  assign push_try = run & push_en & ~clr;
  assign pop_try  = run & pop_en & ~clr;
  assign fits     = ({1'b0, count} + (CW+1)'(nbytes)) <= (CW+1)'(DEPTH);
  assign avail    = count >= CW'(nbytes);
  assign push_ok  = push_try & fits;
  assign pop_ok   = pop_try & avail;
  assign add_n    = push_ok ? CW'(nbytes) : '0;
  assign sub_n    = pop_ok ? CW'(nbytes) : '0;

  always_comb begin
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
      ovf_d    = 1'b0;
      unf_d    = 1'b0;
    end else begin
      wr_ptr_d = wr_ptr + PW'(add_n);
      rd_ptr_d = rd_ptr + PW'(sub_n);
      count_d  = count + add_n - sub_n;
      ovf_d    = ovf | (push_try & ~fits);
      unf_d    = unf | (pop_try & ~avail);
    end
  end

  always_comb begin
    pop_d = '0;
    for (int k = 0; k < LANES; k++) begin
      if (pop_ok && (3'(k) < nbytes))
        pop_d[8*k +: 8] = mem[rd_ptr + PW'(k)];
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      for (int k = 0; k < LANES; k++) begin
        if (3'(k) < nbytes)
          mem[wr_ptr + PW'(k)] <= push_data[8*k +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      ovf      <= 1'b0;
      unf      <= 1'b0;
      pop_data <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      count  <= count_d;
      ovf    <= ovf_d;
      unf    <= unf_d;
      if (pop_try) pop_data <= pop_d;
    end
  end

endmodule

// File: rtl/afifo_watch.sv
module afifo_watch #(
  parameter bit IS_TX  = 1'b1,
  parameter int DEPTH  = 128,
  parameter int THR_W  = 7,
  parameter int WM_W   = 5,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = PW + 1,
  localparam int WDW   = CW - 2
) (
  input  logic [CW-1:0]    count,
  input  logic [THR_W-1:0] thr,
  input  logic [WM_W-1:0]  wm_req,
  input  logic [WM_W-1:0]  wm_mid,
  input  logic [WM_W-1:0]  wm_urg,
  output logic [PW+1:0]    status,
  output logic             lvl_req,
  output logic             lvl_mid,
  output logic             lvl_urg,
  output logic             thr_evt,
  output logic             bound_evt
);

  logic [WDW-1:0] words;
  logic           is_empty, is_full;

  assign words    = count[CW-1:2];
  assign is_empty = (count == '0);
  assign is_full  = (count == CW'(DEPTH));
  assign status   = {is_empty, is_full, count[PW-1:0]};

  generate
    if (IS_TX) begin : g_tx
      assign lvl_req   = words < WDW'(wm_req);
      assign lvl_mid   = words < WDW'(wm_mid);
      assign lvl_urg   = words < WDW'(wm_urg);
      assign thr_evt   = count <= CW'(thr);
      assign bound_evt = is_empty;
    end else begin : g_rx
      assign lvl_req   = words > WDW'(wm_req);
      assign lvl_mid   = words > WDW'(wm_mid);
      assign lvl_urg   = words > WDW'(wm_urg);
      assign thr_evt   = count >= CW'(thr);
      assign bound_evt = is_full;
    end
  endgenerate

endmodule

// File: rtl/afifo_wm.sv
module afifo_wm
  import afifo_pkg::*;
#(
  parameter bit IS_TX  = 1'b1,
  parameter int DEPTH  = 128,
  parameter int THR_W  = 7,
  parameter int WM_W   = 5,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_wr,
  input  logic [1:0]    op_cmd,
  input  logic          cfg_wr,
  input  logic [31:0]   cfg_wdata,
  input  logic          wm_wr,
  input  logic [31:0]   wm_wdata,
  input  logic          push_en,
  input  logic [31:0]   push_data,
  input  logic          pop_en,
  output logic [31:0]   pop_data,
  output logic          running,
  output logic [PW+1:0] status,
  output logic          lvl_req,
  output logic          lvl_mid,
  output logic          lvl_urg,
  output logic          thr_evt,
  output logic          bound_evt,
  output logic          ovf_flag,
  output logic          unf_flag
);

  logic             clr;
  ent_width_e       width;
  logic [THR_W-1:0] thr;
  logic [WM_W-1:0]  wm_req, wm_mid, wm_urg;
  logic [CW-1:0]    count;

  afifo_cfg #(.IS_TX(IS_TX), .DEPTH(DEPTH), .THR_W(THR_W), .WM_W(WM_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .op_cmd(op_cmd),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .wm_wr(wm_wr), .wm_wdata(wm_wdata),
    .running(running), .clr(clr), .width(width), .thr(thr),
    .wm_req(wm_req), .wm_mid(wm_mid), .wm_urg(wm_urg)
  );

  afifo_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr), .run(running),
    .push_en(push_en), .push_data(push_data), .pop_en(pop_en),
    .nbytes(ent_bytes(width)), .count(count), .pop_data(pop_data),
    .ovf(ovf_flag), .unf(unf_flag)
  );

  afifo_watch #(.IS_TX(IS_TX), .DEPTH(DEPTH), .THR_W(THR_W), .WM_W(WM_W)) u_watch (
    .count(count), .thr(thr), .wm_req(wm_req), .wm_mid(wm_mid), .wm_urg(wm_urg),
    .status(status), .lvl_req(lvl_req), .lvl_mid(lvl_mid), .lvl_urg(lvl_urg),
    .thr_evt(thr_evt), .bound_evt(bound_evt)
  );

endmodule

// File: rtl/afifo_wm_chk.sv
module afifo_wm_chk #(
  parameter int PW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_wr,
  input logic [1:0]    op_cmd,
  input logic          push_en,
  input logic          pop_en,
  input logic          running,
  input logic [PW+1:0] status,
  input logic          ovf_flag,
  input logic          unf_flag,
  input logic [31:0]   pop_data
);

  logic clr_cmd;
  assign clr_cmd = op_wr & op_cmd[0];

  // R2: a clear command empties the buffer and drops the flags by the next cycle
  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> (status == {1'b1, {(PW+1){1'b0}}}) && !ovf_flag && !unf_flag && !running);

  // R3: a stopped buffer keeps its status and last popped entry
  a_r3_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !op_wr) |=> ($stable(status) && $stable(pop_data)));

  // R6: full and empty are exclusive
  a_r6_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[PW] && status[PW+1]));

  // R6: at full the level field wraps to zero
  a_r6_full_level: assert property (@(posedge clk) disable iff (!rst_n)
    status[PW] |-> (status[PW-1:0] == '0));

  // R7: a push at full always raises overflow
  a_r7_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (running && push_en && status[PW] && !clr_cmd) |=> ovf_flag);

  // R8: a pop at empty raises underflow and yields zero
  a_r8_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (running && pop_en && status[PW+1] && !clr_cmd) |=> (unf_flag && pop_data == 32'h0));

endmodule

bind afifo_wm afifo_wm_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .op_cmd(op_cmd),
  .push_en(push_en), .pop_en(pop_en), .running(running), .status(status),
  .ovf_flag(ovf_flag), .unf_flag(unf_flag), .pop_data(pop_data)
);

// File: tb/sim_afifo_wm.sv
`timescale 1ns/1ps
module sim_afifo_wm;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_wr = 1'b0;
  logic [1:0]  op_cmd = 2'd0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = 32'h0;
  logic        wm_wr = 1'b0;
  logic [31:0] wm_wdata = 32'h0;
  logic        push_en = 1'b0;
  logic [31:0] push_data = 32'h0;
  logic        pop_en = 1'b0;

  logic [31:0] t_pop, r_pop;
  logic [8:0]  t_st, r_st;
  logic        t_run, r_run, t_req, r_req, t_mid, r_mid, t_urg, r_urg;
  logic        t_thr, r_thr, t_bnd, r_bnd, t_ovf, r_ovf, t_unf, r_unf;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  afifo_wm #(.IS_TX(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .op_cmd(op_cmd),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .wm_wr(wm_wr), .wm_wdata(wm_wdata),
    .push_en(push_en), .push_data(push_data), .pop_en(pop_en), .pop_data(t_pop),
    .running(t_run), .status(t_st), .lvl_req(t_req), .lvl_mid(t_mid), .lvl_urg(t_urg),
    .thr_evt(t_thr), .bound_evt(t_bnd), .ovf_flag(t_ovf), .unf_flag(t_unf)
  );

  afifo_wm #(.IS_TX(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .op_cmd(op_cmd),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .wm_wr(wm_wr), .wm_wdata(wm_wdata),
    .push_en(push_en), .push_data(push_data), .pop_en(pop_en), .pop_data(r_pop),
    .running(r_run), .status(r_st), .lvl_req(r_req), .lvl_mid(r_mid), .lvl_urg(r_urg),
    .thr_evt(r_thr), .bound_evt(r_bnd), .ovf_flag(r_ovf), .unf_flag(r_unf)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_op(input logic [1:0] c);
    op_wr = 1'b1; op_cmd = c; tick(); op_wr = 1'b0;
  endtask

  task automatic do_cfg(input logic [1:0] w, input int th);
    cfg_wr = 1'b1; cfg_wdata = (32'(th) << 2) | 32'(w); tick(); cfg_wr = 1'b0;
  endtask

  task automatic do_push(input logic [31:0] d);
    push_en = 1'b1; push_data = d; tick(); push_en = 1'b0;
  endtask

  task automatic do_pop();
    pop_en = 1'b1; tick(); pop_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 status", 32'(t_st), 32'h100);
    check("R1 running", 32'(t_run), 0);
    check("R1 flags", {30'h0, t_ovf, t_unf}, 0);
    check("R1 tx marks", {29'h0, t_req, t_mid, t_urg}, 3'b111);
    check("R1 rx marks", {29'h0, r_req, r_mid, r_urg}, 3'b000);
    check("R1 tx thr", 32'(t_thr), 1);
    check("R1 rx thr", 32'(r_thr), 0);
    check("R12 tx empty evt", 32'(t_bnd), 1);
    check("R12 rx full evt", 32'(r_bnd), 0);
  endtask

  task automatic t_stopped();
    do_push(32'hCAFE_F00D);
    check("R3 push ignored when stopped", 32'(t_st), 32'h100);
  endtask

  task automatic t_word();
    do_op(2'b10);
    check("R3 started", 32'(t_run), 1);
    do_push(32'h1122_3344);
    do_push(32'h5566_7788);
    check("R4 level 8 bytes", 32'(t_st), 32'h008);
    do_pop();
    check("R5 first word", t_pop, 32'h1122_3344);
    do_pop();
    check("R5 second word", t_pop, 32'h5566_7788);
    check("R6 empty again", 32'(t_st), 32'h100);
  endtask

  task automatic t_byte();
    do_cfg(2'd0, 64);
    do_push(32'h1234_56AB);
    do_push(32'h9999_99CD);
    check("R4 byte level", 32'(t_st), 32'h002);
    do_op(2'b00);
    do_push(32'h0000_00EE);
    do_pop();
    check("R3 stopped level", 32'(t_st), 32'h002);
    check("R3 stopped pop_data", t_pop, 32'h5566_7788);
    do_op(2'b10);
    do_pop();
    check("R4 byte pop zero ext", t_pop, 32'h0000_00AB);
    do_pop();
    check("R4 byte pop second", t_pop, 32'h0000_00CD);
  endtask

  task automatic t_half();
    do_cfg(2'd1, 64);
    do_push(32'h1234_5678);
    do_push(32'hFFFF_9ABC);
    check("R4 half level", 32'(t_st), 32'h004);
    do_pop();
    check("R4 half pop", t_pop, 32'h0000_5678);
    do_pop();
    check("R4 half pop second", t_pop, 32'h0000_9ABC);
    do_cfg(2'd3, 64);
    do_push(32'hA1B2_C3D4);
    check("R4 code 3 is word", 32'(t_st), 32'h004);
    do_pop();
    check("R4 code 3 pop", t_pop, 32'hA1B2_C3D4);
    do_cfg(2'd2, 64);
  endtask

  task automatic t_full();
    for (int i = 0; i < 32; i++) do_push(32'hA000_0000 + 32'(i));
    check("R6 full status", 32'(t_st), 32'h080);
    check("R12 rx full evt", 32'(r_bnd), 1);
    check("R12 tx not empty", 32'(t_bnd), 0);
    check("R11 default tx marks full", {29'h0, t_req, t_mid, t_urg}, 3'b000);
    check("R11 default rx marks full", {29'h0, r_req, r_mid, r_urg}, 3'b111);
    do_push(32'hDEAD_BEEF);
    check("R7 overflow flag", 32'(t_ovf), 1);
    check("R7 level kept", 32'(t_st), 32'h080);
    for (int i = 0; i < 32; i++) begin
      do_pop();
      check("R5 wrap order", t_pop, 32'hA000_0000 + 32'(i));
    end
    check("R12 tx empty evt", 32'(t_bnd), 1);
    do_pop();
    check("R8 underflow flag", 32'(t_unf), 1);
    check("R8 zero data", t_pop, 32'h0);
    check("R8 level kept", 32'(t_st), 32'h100);
  endtask

  task automatic t_clear();
    do_push(32'h0000_0011);
    do_cfg(2'd0, 64);
    do_op(2'b01);
    check("R2 cleared status", 32'(t_st), 32'h100);
    check("R2 flags cleared", {30'h0, t_ovf, t_unf}, 0);
    check("R2 stopped", 32'(t_run), 0);
    do_op(2'b10);
    do_push(32'h0000_0077);
    check("R13 width kept over clear", 32'(t_st), 32'h001);
    do_pop();
    check("R2 fresh data after clear", t_pop, 32'h0000_0077);
    do_cfg(2'd2, 64);
  endtask

  task automatic t_simul();
    for (int i = 0; i < 32; i++) do_push(32'hC000_0000 + 32'(i));
    push_en = 1'b1; push_data = 32'hBEEF_0000; pop_en = 1'b1;
    tick();
    push_en = 1'b0; pop_en = 1'b0;
    check("R9 full push dropped", 32'(t_st), 32'h07C);
    check("R9 pop served", t_pop, 32'hC000_0000);
    check("R9 overflow", 32'(t_ovf), 1);
    do_op(2'b01);
    do_op(2'b10);
    push_en = 1'b1; push_data = 32'h0BAD_CAFE; pop_en = 1'b1;
    tick();
    push_en = 1'b0; pop_en = 1'b0;
    check("R9 empty push kept", 32'(t_st), 32'h004);
    check("R9 empty pop zero", t_pop, 32'h0);
    check("R9 underflow", 32'(t_unf), 1);
  endtask

  task automatic t_thresh();
    do_cfg(2'd2, 8);
    check("R10 tx at 4", 32'(t_thr), 1);
    check("R10 rx at 4", 32'(r_thr), 0);
    do_push(32'h1);
    check("R10 tx at 8", 32'(t_thr), 1);
    check("R10 rx at 8", 32'(r_thr), 1);
    do_push(32'h2);
    check("R10 tx at 12", 32'(t_thr), 0);
    check("R10 rx at 12", 32'(r_thr), 1);
  endtask

  task automatic t_wmark();
    wm_wr = 1'b1; wm_wdata = 32'd3 | (32'd5 << 10) | (32'd1 << 20); tick(); wm_wr = 1'b0;
    check("R11 tx at 3 words", {29'h0, t_req, t_mid, t_urg}, 3'b010);
    check("R11 rx at 3 words", {29'h0, r_req, r_mid, r_urg}, 3'b001);
    do_push(32'h3);
    check("R11 tx at 4 words", {29'h0, t_req, t_mid, t_urg}, 3'b010);
    check("R11 rx at 4 words", {29'h0, r_req, r_mid, r_urg}, 3'b101);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_stopped();
    t_word();
    t_byte();
    t_half();
    t_full();
    t_clear();
    t_simul();
    t_thresh();
    t_wmark();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule